// File: doc/BRIEF.md
# Index-Prefix Operand Resolver

This block sits between the byte-fetch path and the datapath of a small 8-bit processor. It takes opcode bytes one at a time and handles two groups: the register-to-register load group (opcodes 0x40 to 0x7F) and the accumulator arithmetic/logic group (0x80 to 0xBF). For each instruction it works out which register is the source and which is the destination, or which memory address is used. It also keeps track of an optional index prefix byte that redirects the H/L operands to an index register. The block does no arithmetic itself. For the arithmetic group it passes the operation code and the resolved second operand to an external ALU in a one-cycle strobe.

The controller is a five-state machine:

- **FETCH** asks for an opcode or prefix byte. A prefix byte keeps it in FETCH. A register-only instruction moves it to REG. A memory instruction moves it to DISP when a prefix is active and to MEM when none is. The halt opcode moves it to HALT. Any other byte ends at once as an instruction with no effect.
- **DISP** fetches the signed displacement byte and then moves to MEM.
- **REG** performs the register transfer or sends the ALU strobe, then returns to FETCH.
- **MEM** holds the memory request until ready. It then completes the load, store or ALU strobe and returns to FETCH.
- **HALT** is left only by reset.

Every handshake (opcode fetch, displacement fetch, memory access) holds its request until the matching ready input is high at a clock edge.

Top module: `opr_resolver`

## Requirements
- R1: After reset the halt output is low, the prefix is cleared, and the block requests an opcode byte with no memory request, register write or ALU strobe.
- R2: Operand codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory, 7=A. Register select values on the register-file ports are the same 0..7 for B..A, and 8=IXH, 9=IXL, 10=IYH, 11=IYL. For an opcode in 0x40..0x7F other than 0x76, where neither field is 6, register[bits 5:3] is loaded with register[bits 2:0] and nothing else changes.
- R3: After prefix 0xDD, operand codes 4 and 5 select IXH and IXL. After prefix 0xFD, they select IYH and IYL. This applies to instructions that have no memory operand.
- R4: With no prefix, a memory operand uses the HL pair as the address (pair select 0), and no displacement byte is fetched.
- R5: With a prefix, a memory operand causes exactly one more byte to be fetched after the opcode. That byte is sign-extended and added to IX (pair select 1, after 0xDD) or IY (pair select 2, after 0xFD) to form the address.
- R6: In an instruction that has a memory operand, a register operand of code 4 or 5 stays plain H or L even when a prefix is active. This covers opcodes 0x66, 0x6E, 0x74 and 0x75.
- R7: An opcode with destination code 6 writes the value of the source register to the resolved address, with the write-enable high.
- R8: For an opcode in 0x80..0xBF, the ALU strobe rises for exactly one cycle. It carries bits 5:3 as the operation and the register or memory byte selected by bits 2:0 as the operand. No register is written.
- R9: Opcode 0x76 sets the halt output, with or without a prefix. While halted the block neither fetches nor accesses memory. Only reset clears the halt output.
- R10: When a prefix byte directly follows another prefix byte, the first ends as an instruction of its own (one done pulse), and the second becomes the active prefix.
- R11: The prefix is cleared when each instruction completes. An opcode outside the handled groups completes with no register write, memory access or ALU strobe.
- R12: A fetch or memory request is held, with a stable address and direction, until its ready input is sampled high, and the block does not advance before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Requests the next instruction-stream byte |
| fetch_rdy | input | 1 | Fetch byte valid this cycle |
| fetch_data | input | 8 | Fetched byte |
| rf_rd_sel | output | 4 | Register read select (source operand) |
| rf_rd_data | input | 8 | Register read data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_sel | output | 4 | Register write select |
| rf_wr_data | output | 8 | Register write data |
| pair_sel | output | 2 | Address pair select: 0 HL, 1 IX, 2 IY |
| pair_data | input | ADDR_W | Value of the selected pair |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_rdy | input | 1 | Memory access completes this cycle |
| alu_go | output | 1 | One-cycle ALU strobe |
| alu_op | output | 3 | ALU operation (opcode bits 5:3) |
| alu_operand | output | 8 | Resolved second ALU operand |
| done | output | 1 | An instruction completes this cycle |
| halt | output | 1 | Halt flag |

## Verification
The assertions assume that the register file and pair value stay constant while a memory request waits for ready, because the address hold check compares the computed address from cycle to cycle. The stimulus meets this assumption: the modelled register file changes only through the block's own write strobe, and that strobe only fires when an instruction completes. The assertions also assume that ready inputs may be low for any number of cycles. The stimulus drives both ready patterns, always-ready and periodically stalled, across the full opcode sweep under all three prefix states.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    localparam logic [2:0] CODE_H   = 3'd4;
    localparam logic [2:0] CODE_L   = 3'd5;
    localparam logic [2:0] CODE_MEM = 3'd6;

    localparam logic [SEL_W-1:0] SEL_XH = 4'd8;
    localparam logic [SEL_W-1:0] SEL_YH = 4'd10;

    localparam logic [BYTE_W-1:0] OP_PFX_X = 8'hDD;
    localparam logic [BYTE_W-1:0] OP_PFX_Y = 8'hFD;
    localparam logic [BYTE_W-1:0] OP_HALT  = 8'h76;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DISP,
        S_REG,
        S_MEM,
        S_HALT
    } state_t;

    typedef enum logic [1:0] {
        PX_NONE = 2'd0,
        PX_IX   = 2'd1,
        PX_IY   = 2'd2
    } pfx_t;

    // Maps a 3-bit operand code to a register select, honouring the index swap.
    function automatic logic [SEL_W-1:0] remap(logic [2:0] code, pfx_t pfx, logic keep_plain);
        logic [SEL_W-1:0] sel;
        sel = {1'b0, code};
        if (!keep_plain && pfx != PX_NONE && (code == CODE_H || code == CODE_L))
            sel = ((pfx == PX_IX) ? SEL_XH : SEL_YH) + {3'b000, code[0]};
        return sel;
    endfunction

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    input  pfx_t              pfx,
    output logic              is_ld,
    output logic              is_alu,
    output logic              is_halt,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [SEL_W-1:0]  dst_sel,
    output logic [SEL_W-1:0]  src_sel,
    output logic [2:0]        alu_op
);

    logic [2:0] dcode;
    logic [2:0] scode;
    logic       has_mem;

    always_comb begin
        dcode   = op[5:3];
        scode   = op[2:0];
        is_halt = (op == OP_HALT);
        is_ld   = (op[7:6] == 2'b01) && !is_halt;
        is_alu  = (op[7:6] == 2'b10);
        mem_rd  = (is_ld || is_alu) && (scode == CODE_MEM);
        mem_wr  = is_ld && (dcode == CODE_MEM);
        has_mem = mem_rd || mem_wr;
        dst_sel = remap(dcode, pfx, has_mem);
        src_sel = remap(scode, pfx, has_mem);
        alu_op  = op[5:3];
    end

endmodule

// File: rtl/opr_addr.sv
module opr_addr #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offset;

    assign offset = indexed ? {{EXT_W{disp[DISP_W-1]}}, disp} : '0;
    assign addr   = base + offset;

endmodule

// File: rtl/opr_resolver.sv
module opr_resolver
    import opr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    input  logic              fetch_rdy,
    input  logic [7:0]        fetch_data,
    output logic [3:0]        rf_rd_sel,
    input  logic [7:0]        rf_rd_data,
    output logic              rf_wr_en,
    output logic [3:0]        rf_wr_sel,
    output logic [7:0]        rf_wr_data,
    output logic [1:0]        pair_sel,
    input  logic [ADDR_W-1:0] pair_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rdy,
    output logic              alu_go,
    output logic [2:0]        alu_op,
    output logic [7:0]        alu_operand,
    output logic              done,
    output logic              halt
);

    state_t            state, nstate;
    pfx_t              pfx_q;
    logic [BYTE_W-1:0] op_q, disp_q, op_cur, opnd;
    logic              is_ld, is_alu, is_halt, mem_rd, mem_wr, is_pfx, take;
    logic [SEL_W-1:0]  dst_sel, src_sel;

    assign op_cur = (state == S_FETCH) ? fetch_data : op_q;
    assign is_pfx = (fetch_data == OP_PFX_X) || (fetch_data == OP_PFX_Y);
    assign take   = (state == S_FETCH) && fetch_rdy;

    opr_decode u_dec (
        .op      (op_cur),
        .pfx     (pfx_q),
        .is_ld   (is_ld),
        .is_alu  (is_alu),
        .is_halt (is_halt),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .dst_sel (dst_sel),
        .src_sel (src_sel),
        .alu_op  (alu_op)
    );

    opr_addr #(.ADDR_W(ADDR_W), .DISP_W(BYTE_W)) u_addr (
        .base    (pair_data),
        .disp    (disp_q),
        .indexed (pfx_q != PX_NONE),
        .addr    (mem_addr)
    );

    // State and instruction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_FETCH;
            pfx_q  <= PX_NONE;
            op_q   <= '0;
            disp_q <= '0;
            halt   <= 1'b0;
        end else begin
            state <= nstate;
            if (take && is_pfx)
                pfx_q <= (fetch_data == OP_PFX_X) ? PX_IX : PX_IY;
            else if (done)
                pfx_q <= PX_NONE;
            if (take && !is_pfx)
                op_q <= fetch_data;
            if (take && !is_pfx && is_halt)
                halt <= 1'b1;
            if (state == S_DISP && fetch_rdy)
                disp_q <= fetch_data;
        end
    end

    // Next state and outputs
    always_comb begin
        nstate      = state;
        done        = 1'b0;
        fetch_req   = 1'b0;
        mem_req     = 1'b0;
        rf_wr_en    = 1'b0;
        alu_go      = 1'b0;
        opnd        = (state == S_MEM) ? mem_rdata : rf_rd_data;
        rf_rd_sel   = src_sel;
        rf_wr_sel   = dst_sel;
        rf_wr_data  = opnd;
        alu_operand = opnd;
        mem_we      = mem_wr;
        mem_wdata   = rf_rd_data;
        pair_sel    = pfx_q;
        unique case (state)
            S_FETCH: begin
                fetch_req = 1'b1;
                if (fetch_rdy) begin
                    if (is_pfx) begin
                        done = (pfx_q != PX_NONE);
                    end else if (is_halt) begin
                        nstate = S_HALT;
                        done   = 1'b1;
                    end else if (is_ld || is_alu) begin
                        if (mem_rd || mem_wr)
                            nstate = (pfx_q != PX_NONE) ? S_DISP : S_MEM;
                        else
                            nstate = S_REG;
                    end else begin
                        done = 1'b1;
                    end
                end
            end
            S_DISP: begin
                fetch_req = 1'b1;
                if (fetch_rdy)
                    nstate = S_MEM;
            end
            S_REG: begin
                rf_wr_en = is_ld;
                alu_go   = is_alu;
                done     = 1'b1;
                nstate   = S_FETCH;
            end
            S_MEM: begin
                mem_req = 1'b1;
                if (mem_rdy) begin
                    rf_wr_en = is_ld && mem_rd;
                    alu_go   = is_alu;
                    done     = 1'b1;
                    nstate   = S_FETCH;
                end
            end
            S_HALT: begin
                nstate = S_HALT;
            end
            default: nstate = S_FETCH;
        endcase
    end

endmodule

// File: rtl/opr_chk.sv
module opr_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic              fetch_rdy,
    input logic              mem_req,
    input logic              mem_rdy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_wr_en,
    input logic              alu_go,
    input logic              done,
    input logic              halt
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fetch_req && !halt && !mem_req));

    p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && mem_req));

    p_alu_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go |-> (!rf_wr_en && !mem_we));

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!fetch_req && !mem_req && !rf_wr_en && !alu_go));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    p_effect_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || alu_go) |-> done);

    p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_rdy) |=> fetch_req);

    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind opr_resolver opr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .fetch_rdy (fetch_rdy),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rf_wr_en  (rf_wr_en),
    .alu_go    (alu_go),
    .done      (done),
    .halt      (halt)
);

// File: tb/sim_opr_resolver.sv
module sim_opr_resolver;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req, fetch_rdy;
    logic [7:0]  fetch_data;
    logic [3:0]  rf_rd_sel, rf_wr_sel;
    logic [7:0]  rf_rd_data, rf_wr_data;
    logic        rf_wr_en;
    logic [1:0]  pair_sel;
    logic [15:0] pair_data, mem_addr;
    logic        mem_req, mem_we, mem_rdy;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        alu_go;
    logic [2:0]  alu_op;
    logic [7:0]  alu_operand;
    logic        done, halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench-side model state
    logic [7:0]  rf [12];
    logic [7:0]  init_rf [12];
    logic [7:0]  prog [4];
    int          pc, plen, cyc, done_cnt, wr_cnt, alu_cnt;
    int          setup_seq, setup_seen;
    bit          stall;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data, alu_opnd_l;
    logic [2:0]  alu_op_l;
    int          checks, fails;

    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic int xmap(int code, int p, bit keep);
        if (!keep && p != 0 && (code == 4 || code == 5))
            return (p == 1 ? 8 : 10) + (code - 4);
        return code;
    endfunction

    assign fetch_rdy  = (setup_seq == setup_seen) && (pc < plen) && (!stall || cyc[0]);
    assign fetch_data = prog[pc[1:0]];
    assign rf_rd_data = (rf_rd_sel < 4'd12) ? rf[rf_rd_sel] : 8'h00;
    assign pair_data  = (pair_sel == 2'd1) ? {rf[8], rf[9]} :
                        (pair_sel == 2'd2) ? {rf[10], rf[11]} : {rf[4], rf[5]};
    assign mem_rdata  = memf(mem_addr);
    assign mem_rdy    = !stall || (cyc % 3 == 2);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (setup_seq != setup_seen) begin
            setup_seen <= setup_seq;
            for (int i = 0; i < 12; i++) rf[i] <= init_rf[i];
            pc <= 0; done_cnt <= 0; wr_cnt <= 0; alu_cnt <= 0;
        end else begin
            if (fetch_req && fetch_rdy) pc <= pc + 1;
            if (rf_wr_en) rf[rf_wr_sel] <= rf_wr_data;
            if (mem_req && mem_we && mem_rdy) begin
                wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
            end
            if (alu_go) begin
                alu_cnt <= alu_cnt + 1; alu_op_l <= alu_op; alu_opnd_l <= alu_operand;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    opr_resolver u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_rdy(fetch_rdy), .fetch_data(fetch_data),
        .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
        .pair_sel(pair_sel), .pair_data(pair_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .alu_go(alu_go), .alu_op(alu_op), .alu_operand(alu_operand),
        .done(done), .halt(halt)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic start(int seed, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, int len);
        @(negedge clk);
        for (int i = 0; i < 12; i++) init_rf[i] = 8'(i * 37 + seed * 11 + 5);
        prog[0] = b0; prog[1] = b1; prog[2] = b2; prog[3] = 8'h00;
        plen = len;
        setup_seq = setup_seq + 1;
    endtask

    task automatic wait_done(int n, string req);
        bit hit = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (setup_seq == setup_seen && done_cnt >= n) begin hit = 1; break; end
        end
        chk(hit, req, "instruction completion count", 32'(done_cnt), 32'(n));
    endtask

    task automatic cmp_rf(logic [7:0] exp [12], string req);
        bit ok = 1; int bad = 0;
        for (int i = 0; i < 12; i++)
            if (i != 6 && rf[i] !== exp[i]) begin ok = 0; bad = i; end
        chk(ok, req, $sformatf("register %0d", bad), 32'(rf[bad]), 32'(exp[bad]));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sweep(bit stl);
        logic [7:0] exp [12];
        stall = stl;
        for (int p = 0; p < 3; p++) begin
            for (int o = 8'h40; o < 8'hC0; o++) begin
                int d, s, len;
                bit ld, hm;
                logic [7:0] op, disp, pbyte;
                logic [15:0] base, addr;
                string tag;
                if (o == 8'h76) continue;
                op = 8'(o); d = o / 8 % 8; s = o % 8;
                ld = (o < 8'h80);
                hm = ld ? (d == 6 || s == 6) : (s == 6);
                disp = 8'(o * 13 + p * 50);
                pbyte = (p == 1) ? 8'hDD : 8'hFD;
                len = 1 + (p != 0 ? 1 : 0) + ((p != 0 && hm) ? 1 : 0);
                if (p == 0) start(o + p, op, 8'h00, 8'h00, len);
                else        start(o + p, pbyte, op, disp, len);
                for (int i = 0; i < 12; i++) exp[i] = 8'(i * 37 + (o + p) * 11 + 5);
                base = (p == 0) ? {exp[4], exp[5]} : (p == 1) ? {exp[8], exp[9]} : {exp[10], exp[11]};
                addr = base + ((p != 0) ? {{8{disp[7]}}, disp} : 16'h0000);
                wait_done(1, stl ? "R12" : "R2");
                @(negedge clk);
                chk(pc == len, stl ? "R12" : (hm && p != 0 ? "R5" : "R4"),
                    $sformatf("bytes consumed op %h pfx %0d", op, p), 32'(pc), 32'(len));
                if (hm && p != 0 && (d == 4 || d == 5 || s == 4 || s == 5)) tag = "R6";
                else if (hm) tag = (p != 0) ? "R5" : "R4";
                else tag = (p != 0 && (d == 4 || d == 5 || s == 4 || s == 5)) ? "R3" : "R2";
                if (ld) begin
                    if (d == 6) begin
                        chk(wr_cnt == 1 && wr_addr == addr && wr_data == exp[xmap(s, p, 1)], "R7",
                            $sformatf("store op %h pfx %0d addr/data", op, p),
                            {wr_addr, wr_data, 8'(wr_cnt)}, {addr, exp[xmap(s, p, 1)], 8'd1});
                    end else begin
                        if (s == 6) exp[d] = memf(addr);
                        else exp[xmap(d, p, 0)] = exp[xmap(s, p, 0)];
                        chk(wr_cnt == 0 && alu_cnt == 0, tag, "no memory write or ALU strobe",
                            32'(wr_cnt + alu_cnt), 32'd0);
                    end
                end else begin
                    logic [7:0] eo;
                    eo = (s == 6) ? memf(addr) : exp[xmap(s, p, 0)];
                    chk(alu_cnt == 1 && alu_op_l == 3'(d) && alu_opnd_l == eo && wr_cnt == 0, "R8",
                        $sformatf("ALU strobe op %h pfx %0d", op, p),
                        {8'(alu_cnt), 8'(alu_op_l), alu_opnd_l}, {8'd1, 8'(d), eo});
                end
                cmp_rf(exp, tag);
            end
        end
    endtask

    initial begin
        logic [7:0] exp [12];
        checks = 0; fails = 0; cyc = 0; pc = 0; plen = 0;
        setup_seq = 0; setup_seen = 0; stall = 0;
        done_cnt = 0; wr_cnt = 0; alu_cnt = 0;
        for (int i = 0; i < 12; i++) begin init_rf[i] = 8'h00; rf[i] = 8'h00; end
        for (int i = 0; i < 4; i++) prog[i] = 8'h00;

        // R1: reset state
        do_reset();
        chk(halt == 1'b0, "R1", "halt after reset", 32'(halt), 32'd0);
        chk(fetch_req == 1'b1 && mem_req == 1'b0 && rf_wr_en == 1'b0 && alu_go == 1'b0,
            "R1", "port state after reset", {fetch_req, mem_req, rf_wr_en, alu_go}, 32'b1000);

        sweep(1'b0);
        sweep(1'b1);
        stall = 0;

        // R10: stacked prefixes, the later one wins
        start(1, 8'hDD, 8'hFD, 8'h7C, 3);
        for (int i = 0; i < 12; i++) exp[i] = 8'(i * 37 + 11 + 5);
        exp[7] = exp[10];
        wait_done(2, "R10");
        cmp_rf(exp, "R10");
        start(2, 8'hFD, 8'hDD, 8'h65, 3);
        for (int i = 0; i < 12; i++) exp[i] = 8'(i * 37 + 22 + 5);
        exp[8] = exp[9];
        wait_done(2, "R10");
        cmp_rf(exp, "R10");

        // R11: unhandled opcode after prefix completes silently and clears the prefix
        start(3, 8'hDD, 8'h00, 8'h7C, 3);
        for (int i = 0; i < 12; i++) exp[i] = 8'(i * 37 + 33 + 5);
        exp[7] = exp[4];
        wait_done(2, "R11");
        cmp_rf(exp, "R11");
        chk(wr_cnt == 0 && alu_cnt == 0, "R11", "no side effects", 32'(wr_cnt + alu_cnt), 32'd0);

        // R9: halt stops fetching; reset clears it
        start(4, 8'h76, 8'h7C, 8'h00, 2);
        for (int i = 0; i < 12; i++) exp[i] = 8'(i * 37 + 44 + 5);
        wait_done(1, "R9");
        repeat (8) @(negedge clk);
        chk(halt == 1'b1, "R9", "halt flag set", 32'(halt), 32'd1);
        chk(pc == 1 && fetch_req == 1'b0, "R9", "no fetch while halted", 32'(pc), 32'd1);
        cmp_rf(exp, "R9");
        do_reset();
        chk(halt == 1'b0, "R9", "halt cleared by reset", 32'(halt), 32'd0);
        start(5, 8'hFD, 8'h76, 8'h00, 2);
        wait_done(1, "R9");
        repeat (4) @(negedge clk);
        chk(halt == 1'b1 && pc == 2, "R9", "prefixed halt", {halt, 8'(pc)}, {1'b1, 8'd2});
        do_reset();
        chk(halt == 1'b0, "R1", "halt low after second reset", 32'(halt), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog: actual hung expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule